// File: doc/BRIEF.md
# Front-Panel Console Command Sequencer

This block sits between the switches of a minicomputer front panel and the machine's memory bus. It takes five push buttons (load address, examine, deposit, halt and start), together with an 18-bit switch register. It keeps a console address register and a display register, and holds the processor status word locally at the top of the I/O page. Each button press is turned into one console command, and the block carries that command out as a single read or write on a simple request/done bus port.

The block does not decode each button on its own. It remembers the previous console command and merges it with the new one. An examine that follows an examine becomes an examine-step, and a deposit that follows a deposit becomes a deposit-step. A step advances the address by one word before the access. The block reports a 9-bit microstate code for whatever it is doing, in octal: 170 while idle, 016 for a load address, 015 for a hard reset, 070 for an examine, 071 for an examine-step, 073 for a deposit and 074 for a deposit-step. Pressing halt and start together performs a hard console reset.

Top module: `console_seq`

## Requirements
- R1: After the synchronous reset `rst`, `ustate` is octal 170, `bus_req` is 0, and `disp_data` and `addr_lights` are 0. The status word is 0.
- R2: While `ustate` is octal 170, the block waits for input and keeps `bus_req` at 0.
- R3: A load-address press copies `sw` into the console address, clears the remembered previous command, leaves `disp_data` unchanged, and shows octal 016 on `ustate` for one cycle.
- R4: An examine whose previous command was not an examine shows octal 070 and keeps the address. It reads the word at that address, and `disp_data` then holds the data read.
- R5: An examine whose previous command was an examine shows octal 071 and adds 2 to the address before the read.
- R6: A deposit writes `sw[15:0]` at the console address and shows octal 073, leaving `disp_data` unchanged. A deposit whose previous command was a deposit shows octal 074 and adds 2 to the address before the write. A later examine of that address returns the written word.
- R7: A step (code 071 or 074) whose address is at or above octal 777700 keeps the address unchanged.
- R8: The status word answers at address octal 777776 inside the block. Accesses to it never raise `bus_req`, and a deposit of 000340 there followed by an examine returns 000340.
- R9: Pressing halt and start together performs a hard reset. It shows octal 015 for one cycle, clears the status word to 000000, and clears the previous-command memory. The address and the display are kept.
- R10: Each press acts once, however long the button is held. A press that arrives while a command is in progress is ignored. Priority on a simultaneous press is hard reset, then load, then deposit, then examine.
- R11: While `bus_req` is high and `bus_done` is low, `bus_req`, `bus_addr`, `bus_we` and `bus_wdata` stay unchanged. The access ends on the cycle `bus_done` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_load | input | 1 | Load-address button level |
| btn_exam | input | 1 | Examine button level |
| btn_dep | input | 1 | Deposit button level |
| btn_halt | input | 1 | Halt button level |
| btn_start | input | 1 | Start button level |
| sw | input | 18 | Switch register |
| bus_req | output | 1 | Memory access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 18 | Access address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, valid with bus_done |
| bus_done | input | 1 | Access complete |
| disp_data | output | 16 | Data display register |
| addr_lights | output | 18 | Console address register |
| ustate | output | 9 | Microstate code of the current command |

## Verification
The assertions check the following on every cycle:
- `bus_req` stays low while the block is idle.
- The request fields stay steady until `bus_done`.
- The status-word address never reaches the bus.
- A load takes the switches without touching the display.
- A plain examine keeps the address, and a step adds 2 below octal 777700 and holds the address at or above it.
- Codes change only by way of idle.

Only the bench's scenarios can show the data side. This covers the merged command sequences, the values read back after deposits, the status word clearing on a hard reset, and a press during a slow access being dropped.

// File: rtl/console_pkg.sv
package console_pkg;
  typedef enum logic [2:0] {CM_NONE, CM_LOAD, CM_EXAM, CM_DEP, CM_HRST} cmd_t;
  typedef enum logic [1:0] {PV_NONE, PV_EXAM, PV_DEP} prev_t;
  typedef enum logic [1:0] {ST_IDLE, ST_SHOW, ST_BUS, ST_LOCAL} st_t;

  localparam int UW = 9;
  localparam logic [UW-1:0] US_IDLE  = 9'o170;
  localparam logic [UW-1:0] US_EXAM  = 9'o070;
  localparam logic [UW-1:0] US_XSTEP = 9'o071;
  localparam logic [UW-1:0] US_DEP   = 9'o073;
  localparam logic [UW-1:0] US_DSTEP = 9'o074;
  localparam logic [UW-1:0] US_LOAD  = 9'o016;
  localparam logic [UW-1:0] US_HRST  = 9'o015;
endpackage

// File: rtl/console_edge.sv
module console_edge #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] q;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= lvl;
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign rise[i] = lvl[i] & ~q[i];
  end
endmodule

// File: rtl/console_merge.sv
module console_merge
  import console_pkg::*;
#(
  parameter int            AW         = 18,
  parameter logic [AW-1:0] STEP_LIMIT = 18'o777700,
  parameter int            STEP       = 2
) (
  input  cmd_t            cmd,
  input  prev_t           prev,
  input  logic [AW-1:0]   addr,
  output logic [UW-1:0]   code,
  output logic [AW-1:0]   next_addr
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  logic again;
  logic at_top;

  always_comb begin
    again  = (cmd == CM_EXAM && prev == PV_EXAM) || (cmd == CM_DEP && prev == PV_DEP);
    at_top = (addr >= STEP_LIMIT);
    next_addr = (again && !at_top) ? addr + STEP_V : addr;
    case (cmd)
      CM_EXAM: code = again ? US_XSTEP : US_EXAM;
      CM_DEP:  code = again ? US_DSTEP : US_DEP;
      CM_LOAD: code = US_LOAD;
      CM_HRST: code = US_HRST;
      default: code = US_IDLE;
    endcase
  end
endmodule

// File: rtl/console_psw.sv
module console_psw #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (we)    q <= wdata;
  end
endmodule

// File: rtl/console_seq.sv
module console_seq
  import console_pkg::*;
#(
  parameter int            AW         = 18,
  parameter int            DW         = 16,
  parameter logic [AW-1:0] PSW_ADDR   = 18'o777776,
  parameter logic [AW-1:0] STEP_LIMIT = 18'o777700,
  parameter int            STEP       = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          btn_load,
  input  logic          btn_exam,
  input  logic          btn_dep,
  input  logic          btn_halt,
  input  logic          btn_start,
  input  logic [AW-1:0] sw,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_done,
  output logic [DW-1:0] disp_data,
  output logic [AW-1:0] addr_lights,
  output logic [UW-1:0] ustate
);
  localparam int NB = 5;
  localparam int B_LOAD = 0, B_EXAM = 1, B_DEP = 2, B_HALT = 3, B_START = 4;

  logic [NB-1:0] lvl, rise;
  assign lvl = {btn_start, btn_halt, btn_dep, btn_exam, btn_load};

  console_edge #(.N(NB)) u_edge (.clk(clk), .rst(rst), .lvl(lvl), .rise(rise));

  cmd_t cmd;
  always_comb begin
    if (lvl[B_HALT] && lvl[B_START] && (rise[B_HALT] || rise[B_START])) cmd = CM_HRST;
    else if (rise[B_LOAD]) cmd = CM_LOAD;
    else if (rise[B_DEP])  cmd = CM_DEP;
    else if (rise[B_EXAM]) cmd = CM_EXAM;
    else                   cmd = CM_NONE;
  end

  st_t           st;
  prev_t         prev;
  logic [AW-1:0] addr;
  logic [UW-1:0] m_code;
  logic [AW-1:0] m_next;

  console_merge #(.AW(AW), .STEP_LIMIT(STEP_LIMIT), .STEP(STEP)) u_merge (
    .cmd(cmd), .prev(prev), .addr(addr), .code(m_code), .next_addr(m_next)
  );

  logic          psw_clr, psw_we;
  logic [DW-1:0] psw_q;
  assign psw_clr = (st == ST_IDLE) && (cmd == CM_HRST);
  assign psw_we  = (st == ST_LOCAL) && bus_we;

  console_psw #(.DW(DW)) u_psw (
    .clk(clk), .rst(rst), .clr(psw_clr), .we(psw_we), .wdata(bus_wdata), .q(psw_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      prev      <= PV_NONE;
      addr      <= '0;
      disp_data <= '0;
      ustate    <= US_IDLE;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_wdata <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          case (cmd)
            CM_LOAD: begin
              addr   <= sw;
              prev   <= PV_NONE;
              ustate <= m_code;
              st     <= ST_SHOW;
            end
            CM_HRST: begin
              prev   <= PV_NONE;
              ustate <= m_code;
              st     <= ST_SHOW;
            end
            CM_EXAM, CM_DEP: begin
              addr      <= m_next;
              ustate    <= m_code;
              prev      <= (cmd == CM_EXAM) ? PV_EXAM : PV_DEP;
              bus_we    <= (cmd == CM_DEP);
              bus_wdata <= sw[DW-1:0];
              if (m_next == PSW_ADDR) begin
                st <= ST_LOCAL;
              end else begin
                st      <= ST_BUS;
                bus_req <= 1'b1;
              end
            end
            default: ;
          endcase
        end
        ST_SHOW: begin
          st     <= ST_IDLE;
          ustate <= US_IDLE;
        end
        ST_LOCAL: begin
          if (!bus_we) disp_data <= psw_q;
          st     <= ST_IDLE;
          ustate <= US_IDLE;
        end
        ST_BUS: begin
          if (bus_done) begin
            bus_req <= 1'b0;
            if (!bus_we) disp_data <= bus_rdata;
            st     <= ST_IDLE;
            ustate <= US_IDLE;
          end
        end
        default: begin
          st     <= ST_IDLE;
          ustate <= US_IDLE;
        end
      endcase
    end
  end

  assign bus_addr    = addr;
  assign addr_lights = addr;
endmodule

// File: rtl/console_seq_chk.sv
module console_seq_chk
  import console_pkg::*;
#(
  parameter int            AW         = 18,
  parameter int            DW         = 16,
  parameter logic [AW-1:0] PSW_ADDR   = 18'o777776,
  parameter logic [AW-1:0] STEP_LIMIT = 18'o777700,
  parameter int            STEP       = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          btn_load,
  input logic          btn_exam,
  input logic          btn_dep,
  input logic          btn_halt,
  input logic          btn_start,
  input logic [AW-1:0] sw,
  input logic          bus_req,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          bus_done,
  input logic [DW-1:0] disp_data,
  input logic [AW-1:0] addr_lights,
  input logic [UW-1:0] ustate
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (ustate == US_IDLE) |-> !bus_req);

  a_r3_load_takes_switch: assert property (@(posedge clk) disable iff (rst)
    ($past(ustate) == US_IDLE && ustate == US_LOAD)
      |-> (addr_lights == $past(sw) && disp_data == $past(disp_data)));

  a_r4_exam_keeps_addr: assert property (@(posedge clk) disable iff (rst)
    ($past(ustate) == US_IDLE && ustate == US_EXAM)
      |-> (addr_lights == $past(addr_lights)));

  a_r5_step_by_two: assert property (@(posedge clk) disable iff (rst)
    ($past(ustate) == US_IDLE && (ustate == US_XSTEP || ustate == US_DSTEP)
      && $past(addr_lights) < STEP_LIMIT)
      |-> (addr_lights == $past(addr_lights) + STEP_V));

  a_r7_no_step_at_top: assert property (@(posedge clk) disable iff (rst)
    ($past(ustate) == US_IDLE && (ustate == US_XSTEP || ustate == US_DSTEP)
      && $past(addr_lights) >= STEP_LIMIT)
      |-> (addr_lights == $past(addr_lights)));

  a_r8_psw_stays_local: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> (bus_addr != PSW_ADDR));

  a_r11_hold_request: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_done)
      |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

  a_r10_one_command_at_a_time: assert property (@(posedge clk) disable iff (rst)
    (ustate != US_IDLE) |=> (ustate == US_IDLE || $stable(ustate)));
endmodule

bind console_seq console_seq_chk #(
  .AW(AW), .DW(DW), .PSW_ADDR(PSW_ADDR), .STEP_LIMIT(STEP_LIMIT), .STEP(STEP)
) u_chk (.*);

// File: tb/tb_console_seq.sv
`timescale 1ns/1ps
module tb_console_seq;
  localparam int AW = 18;
  localparam int DW = 16;
  localparam logic [AW-1:0] PSW_A = 18'o777776;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          btn_load = 0, btn_exam = 0, btn_dep = 0, btn_halt = 0, btn_start = 0;
  logic [AW-1:0] sw = '0;
  logic          bus_req, bus_we, bus_done;
  logic [AW-1:0] bus_addr, addr_lights;
  logic [DW-1:0] bus_wdata, bus_rdata, disp_data;
  logic [8:0]    ustate;

  always #2 clk = ~clk;

  console_seq dut (
    .clk(clk), .rst(rst), .btn_load(btn_load), .btn_exam(btn_exam), .btn_dep(btn_dep),
    .btn_halt(btn_halt), .btn_start(btn_start), .sw(sw), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_done(bus_done), .disp_data(disp_data), .addr_lights(addr_lights), .ustate(ustate)
  );

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return a[15:0] ^ 16'o052525;
  endfunction

  // memory model: unwritten words read as a pattern of their address
  int            lat = 2;
  int            cnt;
  int            req_cycles;
  logic [DW-1:0] mem [512];
  logic          wr  [512];
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_done   <= 1'b0;
      bus_rdata  <= '0;
      cnt        <= 0;
      req_cycles <= 0;
      for (int i = 0; i < 512; i++) wr[i] <= 1'b0;
    end else begin
      bus_done <= 1'b0;
      if (bus_req) req_cycles <= req_cycles + 1;
      if (bus_req && !bus_done) begin
        if (cnt >= lat) begin
          bus_done <= 1'b1;
          cnt      <= 0;
          if (bus_we) begin
            mem[bus_addr[9:1]] <= bus_wdata;
            wr[bus_addr[9:1]]  <= 1'b1;
          end else begin
            bus_rdata <= wr[bus_addr[9:1]] ? mem[bus_addr[9:1]] : pat(bus_addr);
          end
        end else begin
          cnt <= cnt + 1;
        end
      end
    end
  end

  int checks = 0;
  int errors = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0o expected %0o", tag, act, exp);
    end
  endtask

  // command field: 1 load, 2 examine, 3 deposit, 4 hard reset
  localparam int NV = 22;
  localparam logic [63:0] VEC [NV] = '{
    {3'd1, 18'o001000, 9'o016, 18'o001000, 16'o0},
    {3'd3, 18'o012345, 9'o073, 18'o001000, 16'o0},
    {3'd2, 18'o0,      9'o070, 18'o001000, 16'o012345},
    {3'd2, 18'o0,      9'o071, 18'o001002, pat(18'o001002)},
    {3'd3, 18'o000777, 9'o073, 18'o001002, pat(18'o001002)},
    {3'd3, 18'o000111, 9'o074, 18'o001004, pat(18'o001002)},
    {3'd2, 18'o0,      9'o070, 18'o001004, 16'o000111},
    {3'd1, 18'o777776, 9'o016, 18'o777776, 16'o000111},
    {3'd3, 18'o000340, 9'o073, 18'o777776, 16'o000111},
    {3'd2, 18'o0,      9'o070, 18'o777776, 16'o000340},
    {3'd2, 18'o0,      9'o071, 18'o777776, 16'o000340},
    {3'd1, 18'o777674, 9'o016, 18'o777674, 16'o000340},
    {3'd2, 18'o0,      9'o070, 18'o777674, pat(18'o777674)},
    {3'd2, 18'o0,      9'o071, 18'o777676, pat(18'o777676)},
    {3'd2, 18'o0,      9'o071, 18'o777700, pat(18'o777700)},
    {3'd2, 18'o0,      9'o071, 18'o777700, pat(18'o777700)},
    {3'd4, 18'o0,      9'o015, 18'o777700, pat(18'o777700)},
    {3'd2, 18'o0,      9'o070, 18'o777700, pat(18'o777700)},
    {3'd1, 18'o777776, 9'o016, 18'o777776, pat(18'o777700)},
    {3'd2, 18'o0,      9'o070, 18'o777776, 16'o000000},
    {3'd1, 18'o001002, 9'o016, 18'o001002, 16'o000000},
    {3'd2, 18'o0,      9'o070, 18'o001002, 16'o000777}
  };

  function automatic string tag_of(input logic [2:0] c, input logic [8:0] code,
                                   input logic [AW-1:0] a);
    if (a == PSW_A && (c == 3'd2 || c == 3'd3)) return "R8";
    case (c)
      3'd1: return "R3";
      3'd3: return (code == 9'o074) ? "R6 step" : "R6";
      3'd4: return "R9";
      default: begin
        if (code == 9'o070) return "R4";
        if (a >= 18'o777700) return "R7";
        return "R5";
      end
    endcase
  endfunction

  task automatic set_btn(input logic [2:0] c, input logic v);
    case (c)
      3'd1: btn_load = v;
      3'd2: btn_exam = v;
      3'd3: btn_dep  = v;
      3'd4: begin btn_halt = v; btn_start = v; end
      default: ;
    endcase
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 200 && ustate != 9'o170; k++) @(negedge clk);
  endtask

  task automatic run_cmd(input logic [2:0] c, input logic [AW-1:0] s, output logic [8:0] code);
    @(negedge clk);
    sw = s;
    set_btn(c, 1'b1);
    @(posedge clk);
    #1 code = ustate;
    @(negedge clk);
    wait_idle();
    repeat (3) @(negedge clk);
    set_btn(c, 1'b0);
    @(negedge clk);
  endtask

  logic  done_flag = 1'b0;

  initial begin
    logic [8:0] code;
    int         rc;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 ustate", ustate, 9'o170);
    check("R1 bus_req", bus_req, 0);
    check("R1 disp", disp_data, 0);
    check("R1 addr", addr_lights, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 idle code", ustate, 9'o170);
    check("R2 idle bus", bus_req, 0);

    for (int v = 0; v < NV; v++) begin
      logic [2:0]    c;
      logic [AW-1:0] s, ea;
      logic [8:0]    ec;
      logic [DW-1:0] ed;
      string         t;
      {c, s, ec, ea, ed} = VEC[v];
      t  = tag_of(c, ec, ea);
      rc = req_cycles;
      run_cmd(c, s, code);
      check({t, " code"}, code, ec);
      check({t, " addr"}, addr_lights, ea);
      check({t, " disp"}, disp_data, ed);
      check("R10 held button acted once", ustate, 9'o170);
      if (t == "R8") check("R8 no bus access", req_cycles - rc, 0);
    end

    // R10 / R11: slow access, a deposit press during it is dropped
    lat = 12;
    run_cmd(3'd1, 18'o001000, code);
    rc = req_cycles;
    @(negedge clk);
    btn_exam = 1'b1;
    repeat (3) @(negedge clk);
    sw = 18'o000555;
    btn_dep = 1'b1;
    @(negedge clk);
    btn_dep = 1'b0;
    wait_idle();
    @(negedge clk);
    btn_exam = 1'b0;
    check("R11 request held until done", (req_cycles - rc) >= 12 ? 1 : 0, 1);
    check("R10 addr after ignored press", addr_lights, 18'o001000);
    check("R10 disp after slow read", disp_data, 16'o012345);
    repeat (2) @(negedge clk);
    run_cmd(3'd1, 18'o001000, code);
    run_cmd(3'd2, 18'o0, code);
    check("R10 ignored deposit not written", disp_data, 16'o012345);
    check("R4 plain examine after load", code, 9'o070);
    lat = 2;

    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule